// File: doc/BRIEF.md
# Clock Frequency-Policy Selector

This block holds a small register file on a simple strobe bus and turns its contents into the select and divisor codes that steer a CPU clock tree. Software writes a frequency identifier (FID) into each of four policy slots. An override control either leaves the default slot 0 in force or points at another slot. The FID that results picks the source of the CPU clock. The block also drives fixed-rule divisor codes for the peripheral, free-running APB, switch and APB clocks. It produces codes only. The muxes, dividers and PLLs that act on those codes sit elsewhere.

The resolved FID is registered and can be read back in a read-only status word. A small state machine holds the selected CPU source. It has four states: `SRC_REF`, `SRC_PLL0`, `SRC_PLL1` and `SRC_ALT`. On every clock it takes one of four transitions, `TO_REF`, `TO_PLL0`, `TO_PLL1` or `TO_ALT`, chosen by the FID resolved in the previous cycle. That FID is loaded into the status register on the same edge, so the source code and the reported FID always change together.

Top module: `clk_policy_sel`

## Requirements
- R1: After reset, every register reads zero. In this state `cpu_src` is 0 (reference), `cpu_div` is 1, `active_fid` is 0, `apbfree_div` is 8, `switch_div` is 4, `apb_div` is 4 and `bus_rvalid` is 0.
- R2: A read is a strobe with `bus_valid`=1 and `bus_write`=0. `bus_rvalid` goes high for exactly one cycle, on the cycle after the strobe, and `bus_rdata` carries the addressed word in that cycle. The word map is as follows:
  - Address 0 holds the slots. Slot k sits in bits 8k+2..8k.
  - Addresses 1 to 4 hold one mask word per slot, with two stored bits at 21:20.
  - Address 5 holds the control word: slot index in 3:0, override enable in bit 4, switch code in 6:5, free-APB code in 10:8.
  - Address 6 holds the APB code in bits 1:0.
  - Address 7 holds the status word, with the FID in bits 14:12.
  - Every other bit reads 0.
- R3: With the override bit clear, slot 0 supplies the FID. With it set, the slot named by the index field supplies it. An index of 4 to 15 resolves to FID 0.
- R4: `active_fid` and the status field change exactly one cycle after the write edge that changes the resolved FID. Without a write, they do not change.
- R5: FID 7 gives `cpu_src`=2 (PLL channel 1), and FID 6 gives `cpu_src`=1 (PLL channel 0); both have `cpu_div`=1. FID 2 gives `cpu_src`=3 (secondary clock) with `cpu_div`=2. Any other FID gives `cpu_src`=0 (reference) with `cpu_div`=1. `cpu_src` changes in the same cycle as `active_fid`.
- R6: `apbfree_div` equals the free-APB code, with a code of 0 giving 8. It follows the write on the cycle after the write edge.
- R7: `switch_div` equals the switch code and `apb_div` equals the APB code. A code of 0 gives 4 in both.
- R8: `periph_div` is always 2.
- R9: Writes to the mask words and to the status word leave every clock output unchanged. A write to the status word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| active_fid | output | 3 | Resolved frequency identifier |
| cpu_src | output | 2 | CPU clock source: 0 ref, 1 PLL ch0, 2 PLL ch1, 3 secondary |
| cpu_div | output | 2 | CPU clock divisor (1 or 2) |
| periph_div | output | 2 | Peripheral divisor relative to CPU clock |
| apbfree_div | output | 4 | Free-running APB divisor (1..8) |
| switch_div | output | 3 | Switch clock divisor (1..4) |
| apb_div | output | 3 | APB clock divisor (1..4) |

## Verification
The assertions assume that the bus carries known values whenever reset is released. They also assume that a strobe lasts exactly one cycle per access, so that each read maps to one `bus_rvalid` pulse. The stability check on `active_fid` relies on the resolved FID changing only through bus writes. The stimulus drives all bus inputs from tasks at the falling edge and drops `bus_valid` low again after every single-cycle access. It keeps the bus idle, with all fields at zero, during reset.

// File: rtl/clk_policy_sel_pkg.sv
package clk_policy_sel_pkg;

    typedef enum logic [1:0] {
        SRC_REF  = 2'd0,
        SRC_PLL0 = 2'd1,
        SRC_PLL1 = 2'd2,
        SRC_ALT  = 2'd3
    } src_e;

    localparam int FID_CODE_PLL1 = 7;
    localparam int FID_CODE_PLL0 = 6;
    localparam int FID_CODE_ALT  = 2;

    localparam int SLOT_STRIDE   = 8;
    localparam int STATUS_LSB    = 12;

endpackage

// File: rtl/clk_policy_regs.sv
module clk_policy_regs
    import clk_policy_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int FID_W     = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_valid,
    input  logic                              bus_write,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic [FID_W-1:0]                  active_fid,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              bus_rvalid,
    output logic [NUM_SLOTS-1:0][FID_W-1:0]   slot_fid,
    output logic                              ovr_en,
    output logic [3:0]                        ovr_idx,
    output logic [1:0]                        sw_code,
    output logic [2:0]                        af_code,
    output logic [1:0]                        apb_code
);

    localparam int CTRL_A    = NUM_SLOTS + 1;
    localparam int APB_A     = NUM_SLOTS + 2;
    localparam int STAT_A    = NUM_SLOTS + 3;
    localparam int NUM_WORDS = NUM_SLOTS + 3;

    function automatic logic [DATA_W-1:0] keep_bits(input int a);
        logic [DATA_W-1:0] m;
        m = '0;
        if (a == 0) begin
            for (int i = 0; i < NUM_SLOTS; i++)
                m[SLOT_STRIDE*i +: FID_W] = '1;
        end else if (a <= NUM_SLOTS) begin
            m[21:20] = 2'b11;
        end else if (a == CTRL_A) begin
            m[10:8] = 3'b111;
            m[6:0]  = 7'h7F;
        end else if (a == APB_A) begin
            m[1:0] = 2'b11;
        end
        return m;
    endfunction

    logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
    logic [DATA_W-1:0]                rd_mux;
    logic                             wr_en, rd_en;

    assign wr_en = bus_valid &&  bus_write;
    assign rd_en = bus_valid && !bus_write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NUM_WORDS; w++)
                if (bus_addr == ADDR_W'(w))
                    word_q[w] <= bus_wdata & keep_bits(w);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(STAT_A)) begin
            rd_mux[STATUS_LSB +: FID_W] = active_fid;
        end else begin
            for (int w = 0; w < NUM_WORDS; w++)
                if (bus_addr == ADDR_W'(w))
                    rd_mux = word_q[w];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            bus_rdata  <= rd_en ? rd_mux : '0;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_fid[g] = word_q[0][SLOT_STRIDE*g +: FID_W];
    end

    assign ovr_idx  = word_q[CTRL_A][3:0];
    assign ovr_en   = word_q[CTRL_A][4];
    assign sw_code  = word_q[CTRL_A][6:5];
    assign af_code  = word_q[CTRL_A][10:8];
    assign apb_code = word_q[APB_A][1:0];

endmodule

// File: rtl/clk_policy_resolve.sv
module clk_policy_resolve #(
    parameter int NUM_SLOTS = 4,
    parameter int FID_W     = 3
) (
    input  logic [NUM_SLOTS-1:0][FID_W-1:0] slot_fid,
    input  logic                            ovr_en,
    input  logic [3:0]                      ovr_idx,
    output logic [FID_W-1:0]                fid
);

    always_comb begin
        fid = slot_fid[0];
        if (ovr_en) begin
            fid = '0;
            for (int i = 0; i < NUM_SLOTS; i++)
                if (ovr_idx == 4'(i))
                    fid = slot_fid[i];
        end
    end

endmodule

// File: rtl/clk_policy_src_fsm.sv
module clk_policy_src_fsm
    import clk_policy_sel_pkg::*;
#(
    parameter int FID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FID_W-1:0] fid_in,
    output logic [FID_W-1:0] active_fid,
    output src_e             cpu_src,
    output logic [1:0]       cpu_div
);

    src_e state_q, state_d;

    always_comb begin
        if (fid_in == FID_W'(FID_CODE_PLL1))
            state_d = SRC_PLL1;
        else if (fid_in == FID_W'(FID_CODE_PLL0))
            state_d = SRC_PLL0;
        else if (fid_in == FID_W'(FID_CODE_ALT))
            state_d = SRC_ALT;
        else
            state_d = SRC_REF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SRC_REF;
            active_fid <= '0;
        end else begin
            state_q    <= state_d;
            active_fid <= fid_in;
        end
    end

    always_comb begin
        cpu_src = state_q;
        unique case (state_q)
            SRC_ALT:                      cpu_div = 2'd2;
            SRC_REF, SRC_PLL0, SRC_PLL1:  cpu_div = 2'd1;
            default:                      cpu_div = 2'd1;
        endcase
    end

endmodule

// File: rtl/clk_policy_sel.sv
module clk_policy_sel
    import clk_policy_sel_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int FID_W     = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [FID_W-1:0]  active_fid,
    output logic [1:0]        cpu_src,
    output logic [1:0]        cpu_div,
    output logic [1:0]        periph_div,
    output logic [3:0]        apbfree_div,
    output logic [2:0]        switch_div,
    output logic [2:0]        apb_div
);

    logic [NUM_SLOTS-1:0][FID_W-1:0] slot_fid;
    logic                            ovr_en;
    logic [3:0]                      ovr_idx;
    logic [1:0]                      sw_code, apb_code;
    logic [2:0]                      af_code;
    logic [FID_W-1:0]                fid_res;
    src_e                            src_st;

    clk_policy_regs #(
        .NUM_SLOTS(NUM_SLOTS), .FID_W(FID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .active_fid(active_fid),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .slot_fid(slot_fid), .ovr_en(ovr_en), .ovr_idx(ovr_idx),
        .sw_code(sw_code), .af_code(af_code), .apb_code(apb_code)
    );

    clk_policy_resolve #(
        .NUM_SLOTS(NUM_SLOTS), .FID_W(FID_W)
    ) u_resolve (
        .slot_fid(slot_fid), .ovr_en(ovr_en), .ovr_idx(ovr_idx), .fid(fid_res)
    );

    clk_policy_src_fsm #(
        .FID_W(FID_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .fid_in(fid_res),
        .active_fid(active_fid), .cpu_src(src_st), .cpu_div(cpu_div)
    );

    assign cpu_src     = src_st;
    assign periph_div  = 2'd2;
    assign apbfree_div = (af_code  == 3'd0) ? 4'd8 : {1'b0, af_code};
    assign switch_div  = (sw_code  == 2'd0) ? 3'd4 : {1'b0, sw_code};
    assign apb_div     = (apb_code == 2'd0) ? 3'd4 : {1'b0, apb_code};

endmodule

// File: rtl/clk_policy_sel_chk.sv
module clk_policy_sel_chk #(
    parameter int FID_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             bus_rvalid,
    input logic [FID_W-1:0] active_fid,
    input logic [1:0]       cpu_src,
    input logic [1:0]       cpu_div,
    input logic [3:0]       apbfree_div,
    input logic [2:0]       switch_div,
    input logic [2:0]       apb_div
);

    logic wr_d1, wr_d2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_d1 <= 1'b1;
            wr_d2 <= 1'b1;
        end else begin
            wr_d1 <= bus_valid && bus_write;
            wr_d2 <= wr_d1;
        end
    end

    AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid); // R2
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid); // R2
    AST_FID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_d1 && !wr_d2) |-> $stable(active_fid)); // R4
    AST_SRC_PLL1: assert property (@(posedge clk) disable iff (!rst_n)
        (active_fid == FID_W'(7)) == (cpu_src == 2'd2)); // R5
    AST_SRC_PLL0: assert property (@(posedge clk) disable iff (!rst_n)
        (active_fid == FID_W'(6)) == (cpu_src == 2'd1)); // R5
    AST_SRC_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (active_fid == FID_W'(2)) == (cpu_src == 2'd3)); // R5
    AST_CPU_DIV_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_div == 2'd2) == (cpu_src == 2'd3)); // R5
    AST_APBFREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (apbfree_div != 4'd0) && (apbfree_div <= 4'd8)); // R6
    AST_SWITCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_div != 3'd0) && (switch_div <= 3'd4)); // R7
    AST_APB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_div != 3'd0) && (apb_div <= 3'd4)); // R7

endmodule

bind clk_policy_sel clk_policy_sel_chk #(.FID_W(FID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_rvalid(bus_rvalid), .active_fid(active_fid), .cpu_src(cpu_src),
    .cpu_div(cpu_div), .apbfree_div(apbfree_div), .switch_div(switch_div),
    .apb_div(apb_div)
);

// File: tb/clk_policy_sel_test.sv
`timescale 1ns/1ps
module clk_policy_sel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [2:0]  active_fid;
    logic [1:0]  cpu_src, cpu_div, periph_div;
    logic [3:0]  apbfree_div;
    logic [2:0]  switch_div, apb_div;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    clk_policy_sel uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .active_fid(active_fid), .cpu_src(cpu_src),
        .cpu_div(cpu_div), .periph_div(periph_div), .apbfree_div(apbfree_div),
        .switch_div(switch_div), .apb_div(apb_div)
    );

    // behavioural reference state
    int m_slot [4];
    int m_mask [4];
    int m_idx, m_ovr, m_sw, m_af, m_apb, m_fid;
    int m_rvalid, m_rdata;

    function automatic int ref_word(int a);
        case (a)
            0: return m_slot[0] | (m_slot[1] << 8) | (m_slot[2] << 16) | (m_slot[3] << 24);
            1, 2, 3, 4: return m_mask[a-1] << 20;
            5: return m_idx | (m_ovr << 4) | (m_sw << 5) | (m_af << 8);
            6: return m_apb;
            default: return m_fid << 12;
        endcase
    endfunction

    function automatic int ref_fid();
        if (m_ovr == 0) return m_slot[0];
        if (m_idx < 4)  return m_slot[m_idx];
        return 0;
    endfunction

    function automatic int ref_src(int f);
        if (f == 7) return 2;
        if (f == 6) return 1;
        if (f == 2) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_slot[i]) begin m_slot[i] = 0; m_mask[i] = 0; end
            m_idx = 0; m_ovr = 0; m_sw = 0; m_af = 0; m_apb = 0; m_fid = 0;
            m_rvalid = 0; m_rdata = 0;
        end else begin
            int nf;
            m_rvalid = (bus_valid && !bus_write) ? 1 : 0;
            m_rdata  = m_rvalid ? ref_word(int'(bus_addr)) : 0;
            nf = ref_fid();
            if (bus_valid && bus_write) begin
                case (int'(bus_addr))
                    0: for (int i = 0; i < 4; i++) m_slot[i] = int'((bus_wdata >> (8*i)) & 32'h7);
                    1, 2, 3, 4: m_mask[int'(bus_addr)-1] = int'((bus_wdata >> 20) & 32'h3);
                    5: begin
                        m_idx = int'(bus_wdata & 32'hF);
                        m_ovr = int'((bus_wdata >> 4) & 32'h1);
                        m_sw  = int'((bus_wdata >> 5) & 32'h3);
                        m_af  = int'((bus_wdata >> 8) & 32'h7);
                    end
                    6: m_apb = int'(bus_wdata & 32'h3);
                    default: ;
                endcase
            end
            m_fid = nf;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 active_fid", int'(active_fid), m_fid);
            chk("R5 cpu_src", int'(cpu_src), ref_src(m_fid));
            chk("R5 cpu_div", int'(cpu_div), (m_fid == 2) ? 2 : 1);
            chk("R8 periph_div", int'(periph_div), 2);
            chk("R6 apbfree_div", int'(apbfree_div), (m_af == 0) ? 8 : m_af);
            chk("R7 switch_div", int'(switch_div), (m_sw == 0) ? 4 : m_sw);
            chk("R7 apb_div", int'(apb_div), (m_apb == 0) ? 4 : m_apb);
            chk("R2 rvalid", int'(bus_rvalid), m_rvalid);
            if (m_rvalid != 0) chk("R2 rdata", int'(bus_rdata), m_rdata);
        end
    end

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input int a);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'(a);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cpu_src", int'(cpu_src), 0);
        chk("R1 active_fid", int'(active_fid), 0);
        chk("R1 apbfree_div", int'(apbfree_div), 8);
        chk("R1 switch_div", int'(switch_div), 4);
        chk("R1 apb_div", int'(apb_div), 4);
        chk("R1 rvalid", int'(bus_rvalid), 0);

        // R5 each interesting FID through slot 0
        bus_wr(0, 32'h0000_0007); idle(1);
        chk("R5 pll1", int'(cpu_src), 2);
        bus_wr(0, 32'h0000_0006); idle(1);
        chk("R5 pll0", int'(cpu_src), 1);
        bus_wr(0, 32'h0000_0002); idle(1);
        chk("R5 alt", int'(cpu_src), 3);
        chk("R5 alt div", int'(cpu_div), 2);
        bus_wr(0, 32'h0000_0005); idle(1);
        chk("R5 ref", int'(cpu_src), 0);

        // R3 override picks slot 2, then out-of-range index
        bus_wr(0, 32'h0307_0605);
        bus_wr(5, 32'h0000_0012); idle(1);
        chk("R3 slot2", int'(active_fid), 7);
        bus_rd(7);
        bus_wr(5, 32'h0000_0019); idle(1);
        chk("R3 idx9", int'(active_fid), 0);
        bus_wr(5, 32'h0000_0003); idle(1);
        chk("R3 no_ovr", int'(active_fid), 5);

        // R6 / R7 zero and nonzero codes
        bus_wr(5, 32'h0000_0540);
        chk("R6 af5", int'(apbfree_div), 5);
        chk("R7 sw2", int'(switch_div), 2);
        bus_wr(6, 32'h0000_0003);
        chk("R7 apb3", int'(apb_div), 3);
        bus_wr(5, 32'h0000_0000);
        chk("R6 af0", int'(apbfree_div), 8);

        // R9 mask and status writes have no effect on outputs
        bus_wr(0, 32'h0000_0006); idle(1);
        bus_wr(1, 32'hFFFF_FFFF);
        bus_wr(4, 32'hFFFF_FFFF);
        bus_wr(7, 32'hFFFF_FFFF); idle(2);
        chk("R9 src", int'(cpu_src), 1);
        chk("R9 fid", int'(active_fid), 6);
        chk("R9 af", int'(apbfree_div), 8);
        bus_rd(7);
        bus_rd(1);
        bus_rd(0);

        // randomized traffic compared against the model
        for (int k = 0; k < 3000; k++) begin
            int a;
            a = int'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) bus_wr(a, $urandom());
            else bus_rd(a);
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule